// File: doc/BRIEF.md
# Password-Gated Supervisor Control Register

This block is the 8-bit control register of a power supervisor. It holds a lock-enable bit, a volatile status flag, a 3-bit watchdog period code and a 3-bit block-lock code. Host accesses arrive already decoded: an address, data, and one qualifier for each direction. The qualifier tells the block whether the matching array password was presented. A register access is any access at the all-ones address.

A write is refused when the hardware protect pin and the stored lock-enable bit are both high. It is also refused when the write password was not presented. Each write to the control address ends in exactly one one-cycle pulse: accepted or rejected. A power-fail event clears the flag bit. A watchdog reset leaves every bit alone, so software can later tell the two causes of reset apart. At power-on, the non-volatile bits come from a reset-value input and the flag starts at 0.

Top module: `sup_ctrl_reg`

## Requirements
- R1: While `por_n` is low, `ctrl_q` equals `{reset_value[7], 1'b0, reset_value[5:0]}`. `write_ack`, `write_rejected`, `rd_valid` and `rd_data` are all 0.
- R2: The field outputs are fixed slices of `ctrl_q`: `lock_en` = bit 7, `flag` = bit 6, `wd_period` = bits 5:3, `block_lock` = bits 2:0.
- R3: A write is accepted when `wr_en` is high, `wr_addr` is all ones (16'hFFFF), `wr_pw_ok` is high, and `wp_pin` and bit 7 are not both high. One cycle later, `ctrl_q` equals `wr_data` and `write_ack` is high for one cycle.
- R4: A write to the control address while `wp_pin` and bit 7 are both high is blocked, even if `wr_pw_ok` is high. One cycle later, `write_rejected` is high for one cycle and bits 7 and 5:0 are unchanged.
- R5: A write to the control address with `wr_pw_ok` low is rejected. `write_rejected` pulses and the register is unchanged.
- R6: A write to any address other than all ones changes nothing and raises neither pulse.
- R7: `power_fail` high clears bit 6 on the next edge and leaves the other bits as they were. If an accepted write happens in the same cycle, the write still loads the other bits, but bit 6 ends at 0.
- R8: `wdog_reset` changes no bit of the register.
- R9: `rd_en` with `rd_addr` all ones and `rd_pw_ok` high gives, one cycle later, `rd_valid` = 1 and `rd_data` equal to `ctrl_q` as it was at the request. Any other read gives `rd_valid` = 0 and `rd_data` = 0.
- R10: `write_ack` and `write_rejected` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| reset_value | input | 8 | Non-volatile contents loaded at power-on |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| wr_pw_ok | input | 1 | Valid array write password presented |
| wp_pin | input | 1 | Hardware write-protect pin |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 16 | Read address |
| rd_pw_ok | input | 1 | Valid array read password presented |
| power_fail | input | 1 | Low-voltage detect event |
| wdog_reset | input | 1 | Watchdog reset event |
| ctrl_q | output | 8 | Register contents |
| lock_en | output | 1 | Lock-enable bit |
| flag | output | 1 | Volatile flag bit |
| wd_period | output | 3 | Watchdog period code |
| block_lock | output | 3 | Block-lock code |
| write_ack | output | 1 | Accepted-write pulse |
| write_rejected | output | 1 | Rejected-write pulse |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |

## Verification
The bench builds the block with its default 16-bit address, so the control address is 16'hFFFF. Random addresses are biased toward that value, which makes the few neighbouring addresses that differ in a single bit reachable as near-miss cases. Random traffic often sets bit 7, so the locked state, and the task of writing bit 7 back to 0 while the pin is high, come up repeatedly. Directed steps cover power-fail colliding with a write, watchdog resets and a read in the same cycle as a write.

// File: rtl/sup_ctrl_reg.sv
module sup_ctrl_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [7:0]        reset_value,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wr_pw_ok,
  input  logic              wp_pin,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_pw_ok,
  input  logic              power_fail,
  input  logic              wdog_reset,
  output logic [7:0]        ctrl_q,
  output logic              lock_en,
  output logic              flag,
  output logic [2:0]        wd_period,
  output logic [2:0]        block_lock,
  output logic              write_ack,
  output logic              write_rejected,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = {ADDR_W{1'b1}};

  logic       nv_lock;
  logic [5:0] nv_fields;
  logic       flag_q;
  logic       wr_hit, hw_locked, accept;

  assign wr_hit    = wr_en && (wr_addr == CTRL_ADDR);
  assign hw_locked = wp_pin && nv_lock;
  assign accept    = wr_hit && wr_pw_ok && !hw_locked;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      nv_lock   <= reset_value[7];
      nv_fields <= reset_value[5:0];
    end else if (accept) begin
      nv_lock   <= wr_data[7];
      nv_fields <= wr_data[5:0];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          flag_q <= 1'b0;
    else if (power_fail) flag_q <= 1'b0;
    else if (accept)     flag_q <= wr_data[6];
    else if (wdog_reset) flag_q <= flag_q;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      write_ack      <= 1'b0;
      write_rejected <= 1'b0;
    end else begin
      write_ack      <= accept;
      write_rejected <= wr_hit && !accept;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (rd_en && rd_pw_ok && (rd_addr == CTRL_ADDR)) begin
      rd_valid <= 1'b1;
      rd_data  <= ctrl_q;
    end else begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end
  end

  assign ctrl_q     = {nv_lock, flag_q, nv_fields};
  assign lock_en    = ctrl_q[7];
  assign flag       = ctrl_q[6];
  assign wd_period  = ctrl_q[5:3];
  assign block_lock = ctrl_q[2:0];
endmodule

module sup_ctrl_reg_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              wr_pw_ok,
  input logic              wp_pin,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_pw_ok,
  input logic              power_fail,
  input logic              wdog_reset,
  input logic [7:0]        ctrl_q,
  input logic              write_ack,
  input logic              write_rejected,
  input logic              rd_valid,
  input logic [7:0]        rd_data
);
  localparam logic [ADDR_W-1:0] CA = {ADDR_W{1'b1}};

  AST_RESET_QUIET: assert property (@(posedge clk) !por_n |-> !write_ack && !write_rejected && !rd_valid); // R1
  AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!por_n)
    wr_en && wr_addr == CA && wr_pw_ok && !(wp_pin && ctrl_q[7]) && !power_fail
    |=> write_ack && ctrl_q == $past(wr_data)); // R3
  AST_HW_LOCK: assert property (@(posedge clk) disable iff (!por_n)
    wr_en && wr_addr == CA && wp_pin && ctrl_q[7]
    |=> write_rejected && ctrl_q[7] && ctrl_q[5:0] == $past(ctrl_q[5:0])); // R4
  AST_NO_PASSWORD: assert property (@(posedge clk) disable iff (!por_n)
    wr_en && wr_addr == CA && !wr_pw_ok |=> write_rejected && ctrl_q[7] == $past(ctrl_q[7])
    && ctrl_q[5:0] == $past(ctrl_q[5:0])); // R5
  AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!por_n)
    !(wr_en && wr_addr == CA) |=> !write_ack && !write_rejected); // R6
  AST_PF_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    power_fail |=> !ctrl_q[6]); // R7
  AST_WDOG_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    wdog_reset && !wr_en && !power_fail |=> $stable(ctrl_q)); // R8
  AST_READ_GATE: assert property (@(posedge clk) disable iff (!por_n)
    !(rd_en && rd_pw_ok && rd_addr == CA) |=> !rd_valid && rd_data == 8'h00); // R9
  AST_READ_DATA: assert property (@(posedge clk) disable iff (!por_n)
    rd_en && rd_pw_ok && rd_addr == CA |=> rd_valid && rd_data == $past(ctrl_q)); // R9
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({write_ack, write_rejected})); // R10
endmodule

bind sup_ctrl_reg sup_ctrl_reg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_pw_ok(wr_pw_ok), .wp_pin(wp_pin), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_pw_ok(rd_pw_ok), .power_fail(power_fail), .wdog_reset(wdog_reset),
  .ctrl_q(ctrl_q), .write_ack(write_ack), .write_rejected(write_rejected),
  .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/sup_ctrl_reg_bench.sv
`timescale 1ns/100ps
module sup_ctrl_reg_bench;
  logic clk = 1'b0, por_n = 1'b0;
  logic [7:0] reset_value = 8'hE5;
  logic wr_en = 0, wr_pw_ok = 0, wp_pin = 0, rd_en = 0, rd_pw_ok = 0;
  logic power_fail = 0, wdog_reset = 0;
  logic [15:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] ctrl_q, rd_data;
  logic lock_en, flag, write_ack, write_rejected, rd_valid;
  logic [2:0] wd_period, block_lock;
  int tests = 0, fails = 0;
  logic [7:0] m;

  always #2.5 clk = ~clk;

  sup_ctrl_reg u_sup_ctrl_reg (
    .clk(clk), .por_n(por_n), .reset_value(reset_value), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_pw_ok(wr_pw_ok), .wp_pin(wp_pin), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_pw_ok(rd_pw_ok), .power_fail(power_fail), .wdog_reset(wdog_reset), .ctrl_q(ctrl_q),
    .lock_en(lock_en), .flag(flag), .wd_period(wd_period), .block_lock(block_lock),
    .write_ack(write_ack), .write_rejected(write_rejected), .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic check(string req, string what, logic [15:0] got, logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] next_reg(logic [7:0] cur, logic acc, logic [7:0] d, logic pf);
    logic [7:0] n;
    n = acc ? d : cur;
    if (pf) n[6] = 1'b0;
    return n;
  endfunction

  task automatic step(logic we, logic [15:0] wa, logic [7:0] wd, logic wpw, logic wp,
                      logic re, logic [15:0] ra, logic rpw, logic pf, logic wdg);
    logic hit, acc, rv;
    logic [7:0] em, erd;
    string req;
    wr_en = we; wr_addr = wa; wr_data = wd; wr_pw_ok = wpw; wp_pin = wp;
    rd_en = re; rd_addr = ra; rd_pw_ok = rpw; power_fail = pf; wdog_reset = wdg;
    hit = we && wa == 16'hFFFF;
    acc = hit && wpw && !(wp && m[7]);
    rv  = re && rpw && ra == 16'hFFFF;
    erd = rv ? m : 8'h00;
    em  = next_reg(m, acc, wd, pf);
    if (pf) req = "R7";
    else if (acc) req = "R3";
    else if (hit && wp && m[7]) req = "R4";
    else if (hit) req = "R5";
    else if (we) req = "R6";
    else if (wdg) req = "R8";
    else req = "R2";
    @(posedge clk); #1;
    check(req, "ctrl_q", {8'h0, ctrl_q}, {8'h0, em});
    check(req, "ack/rej", {14'h0, write_ack, write_rejected}, {14'h0, acc, hit && !acc});
    check("R9", "rd", {7'h0, rd_valid, rd_data}, {7'h0, rv, erd});
    check("R10", "pulses", {15'h0, write_ack && write_rejected}, 16'h0);
    check("R2", "fields", {lock_en, flag, wd_period, block_lock}, ctrl_q);
    m = em;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", "reset ctrl_q", {8'h0, ctrl_q}, 16'h00A5);
    check("R1", "reset outputs", {13'h0, write_ack, write_rejected, rd_valid}, 16'h0);
    por_n = 1'b1;
    m = 8'hA5;
    @(negedge clk);
    // R4 locked from reset (bit7=1) with pin high and password
    step(1, 16'hFFFF, 8'h00, 1, 1, 0, 0, 0, 0, 0);
    // R3 pin low: accepted, flag set
    step(1, 16'hFFFF, 8'hC3, 1, 0, 1, 16'hFFFF, 1, 0, 0);
    // R5 no password
    step(1, 16'hFFFF, 8'h12, 0, 0, 0, 0, 0, 0, 0);
    // R6 near-miss address
    step(1, 16'hFFFE, 8'h12, 1, 0, 0, 0, 0, 0, 0);
    step(1, 16'h7FFF, 8'h12, 1, 0, 0, 0, 0, 0, 0);
    // R8 watchdog reset keeps flag
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R9 read without password, wrong address, then valid
    step(0, 0, 0, 0, 0, 1, 16'hFFFF, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 16'hFFFE, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 16'hFFFF, 1, 0, 0);
    // R7 power fail together with a write that sets the flag
    step(1, 16'hFFFF, 8'h7F, 1, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] wa, ra;
      wa = ($urandom % 2) ? 16'hFFFF : (($urandom % 2) ? (16'hFFFF ^ (16'h1 << ($urandom % 16))) : 16'($urandom));
      ra = ($urandom % 2) ? 16'hFFFF : 16'($urandom);
      step(1'($urandom % 2), wa, 8'($urandom), 1'($urandom % 4 != 0), 1'($urandom % 2),
           1'($urandom % 2), ra, 1'($urandom % 4 != 0), 1'($urandom % 10 == 0), 1'($urandom % 5 == 0));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule